// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block sits beside the FIFOs of a UART and turns their occupancy into interrupt state. Each cycle it rebuilds a live status word from the receive and transmit counts and two programmable trigger levels. Selected live conditions and datapath event strobes (overrun, framing error, parity error, receive timeout, modem status change, transmit overflow) are collected into a sticky pending register. One interrupt line is raised whenever a pending condition is also enabled in the mask.

Software reaches the block through a simple write port: a select code, a data word and a write strobe. The mask can be set by OR through one select and cleared through another. A write aimed at the mask itself changes nothing. Pending bits are cleared by writing ones. The trigger levels are loaded through two further select codes. Status, mask, pending and trigger values are presented on output ports so that an external bus decoder can return them on reads.

Top module: `uart_irq_unit`

## Requirements
- R1: The live status word `status_o` follows the current counts in the same cycle. Bit 0 is set when the RX count is at or above the RX trigger level. Bit 1 is set when the RX count is zero and bit 2 when it equals the FIFO depth (64). Bit 3 is set when the TX count is zero and bit 4 when it equals the FIFO depth. Every status bit except bits 0-4 and 13 is zero.
- R2: Status bit 13 is set when the TX count is at or above the TX trigger level. In the pending register the same condition is captured at bit 10.
- R3: At each clock edge, pending bits 0-4 are ORed with status bits 0-4 of that cycle, and pending bit 10 is ORed with status bit 13. A pending bit stays set until software clears it.
- R4: A write with select 3 clears every pending bit whose data bit is 1. A condition that sets a pending bit in the same cycle takes precedence over the clear.
- R5: A write with select 0 ORs the data into the mask, and a write with select 1 clears the mask bits that are 1 in the data. A write with select 2 leaves the mask unchanged.
- R6: `irq_o` is high exactly when the bitwise AND of mask and pending is nonzero.
- R7: The event strobes set these pending bits at the next edge: RX overrun bit 5, framing bit 6, parity bit 7, receive timeout bit 8, modem status bit 9, TX overflow bit 12.
- R8: While reset is asserted, mask and pending read zero and both trigger levels read 32.
- R9: A write with select 4 loads data bits [5:0] into the RX trigger level, and a write with select 5 loads them into the TX trigger level. Selects 6 and 7 change no state.
- R10: Pending bits 11 and 13 and mask bits 11 and 13 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_count_i | input | 7 | Receive FIFO occupancy, 0 to 64 |
| tx_count_i | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| ev_rx_ovr_i | input | 1 | Receive overrun strobe |
| ev_frame_i | input | 1 | Framing error strobe |
| ev_parity_i | input | 1 | Parity error strobe |
| ev_timeout_i | input | 1 | Receive timeout strobe |
| ev_modem_i | input | 1 | Modem status change strobe |
| ev_tx_ovf_i | input | 1 | Transmit overflow strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 mask set, 1 mask clear, 2 mask (ignored), 3 pending clear, 4 RX trigger, 5 TX trigger |
| wr_data_i | input | 14 | Write data |
| status_o | output | 14 | Live status word |
| mask_o | output | 14 | Interrupt mask |
| pending_o | output | 14 | Sticky pending register |
| rx_trig_o | output | 6 | RX trigger level |
| tx_trig_o | output | 6 | TX trigger level |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a pending-clear write that lands in the same cycle as an event strobe or a still-true live condition for the same bit. A clear is only visible if the bit then actually drops. The stimulus therefore draws counts heavily from the empty, full and exact-trigger values. It also walks the trigger levels to 0 and 63, so that live conditions switch often. Directed cycles pair a full clear with all event strobes at once, and separately clear bits whose live condition has already gone away.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int REG_W = 14;

  // live status positions
  localparam int ST_RX_TRIG  = 0;
  localparam int ST_RX_EMPTY = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_EMPTY = 3;
  localparam int ST_TX_FULL  = 4;
  localparam int ST_TX_TRIG  = 13;

  // pending positions beyond the mirrored low bits
  localparam int PD_RX_OVR   = 5;
  localparam int PD_FRAME    = 6;
  localparam int PD_PARITY   = 7;
  localparam int PD_TIMEOUT  = 8;
  localparam int PD_MODEM    = 9;
  localparam int PD_TX_TRIG  = 10;
  localparam int PD_TX_OVF   = 12;

  localparam int MIRROR_N    = 5;

  localparam logic [REG_W-1:0] PEND_IMPL = 14'h17FF;

  typedef enum logic [2:0] {
    SEL_MASK_SET  = 3'd0,
    SEL_MASK_CLR  = 3'd1,
    SEL_MASK_RO   = 3'd2,
    SEL_PEND_CLR  = 3'd3,
    SEL_RX_TRIG   = 3'd4,
    SEL_TX_TRIG   = 3'd5,
    SEL_SPARE6    = 3'd6,
    SEL_SPARE7    = 3'd7
  } wr_sel_e;

endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 7,
  parameter int TRIG_W     = 6
) (
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [TRIG_W-1:0] rx_lvl_i,
  input  logic [TRIG_W-1:0] tx_lvl_i,
  output logic [REG_W-1:0]  live_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [CNT_W-1:0] rx_lvl_ext;
  logic [CNT_W-1:0] tx_lvl_ext;

  assign rx_lvl_ext = CNT_W'(rx_lvl_i);
  assign tx_lvl_ext = CNT_W'(tx_lvl_i);

  always_comb begin
    live_o              = '0;
    live_o[ST_RX_TRIG]  = (rx_cnt_i >= rx_lvl_ext);
    live_o[ST_RX_EMPTY] = (rx_cnt_i == '0);
    live_o[ST_RX_FULL]  = (rx_cnt_i == FULL_CNT);
    live_o[ST_TX_EMPTY] = (tx_cnt_i == '0);
    live_o[ST_TX_FULL]  = (tx_cnt_i == FULL_CNT);
    live_o[ST_TX_TRIG]  = (tx_cnt_i >= tx_lvl_ext);
  end

endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] live_i,
  input  logic [REG_W-1:0] event_i,
  input  logic             clr_en_i,
  input  logic [REG_W-1:0] clr_bits_i,
  output logic [REG_W-1:0] pend_o
);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] pend_d;
  logic [REG_W-1:0] pend_q;

  // low live bits land at the same positions, TX trigger moves
  always_comb begin
    set_vec = event_i;
    for (int i = 0; i < MIRROR_N; i++) begin
      set_vec[i] = set_vec[i] | live_i[i];
    end
    set_vec[PD_TX_TRIG] = set_vec[PD_TX_TRIG] | live_i[ST_TX_TRIG];
  end

  // set after clear so a fresh condition survives a simultaneous clear
  always_comb begin
    pend_d = pend_q;
    if (clr_en_i) begin
      pend_d = pend_d & ~clr_bits_i;
    end
    pend_d = (pend_d | set_vec) & PEND_IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int TRIG_W   = 6,
  parameter int TRIG_RST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  wr_sel_e           wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  mask_o,
  output logic [TRIG_W-1:0] rx_lvl_o,
  output logic [TRIG_W-1:0] tx_lvl_o
);

  localparam int N_LVL = 2;
  localparam logic [TRIG_W-1:0] LVL_RST = TRIG_W'(TRIG_RST);

  logic [REG_W-1:0] mask_d;
  logic [REG_W-1:0] mask_q;
  logic             mask_en;

  always_comb begin
    mask_d  = mask_q;
    mask_en = 1'b0;
    if (wr_en_i && (wr_sel_i == SEL_MASK_SET)) begin
      mask_d  = (mask_q | wr_data_i) & PEND_IMPL;
      mask_en = 1'b1;
    end else if (wr_en_i && (wr_sel_i == SEL_MASK_CLR)) begin
      mask_d  = mask_q & ~wr_data_i;
      mask_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  logic [TRIG_W-1:0] lvl_q [N_LVL];

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    localparam wr_sel_e MY_SEL = (g == 0) ? SEL_RX_TRIG : SEL_TX_TRIG;
    logic lvl_en;
    assign lvl_en = wr_en_i && (wr_sel_i == MY_SEL);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q[g] <= LVL_RST;
      end else if (lvl_en) begin
        lvl_q[g] <= wr_data_i[TRIG_W-1:0];
      end
    end
  end

  assign rx_lvl_o = lvl_q[0];
  assign tx_lvl_o = lvl_q[1];

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int TRIG_W     = $clog2(FIFO_DEPTH),
  parameter int TRIG_RST   = FIFO_DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic              ev_rx_ovr_i,
  input  logic              ev_frame_i,
  input  logic              ev_parity_i,
  input  logic              ev_timeout_i,
  input  logic              ev_modem_i,
  input  logic              ev_tx_ovf_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [13:0]       wr_data_i,
  output logic [13:0]       status_o,
  output logic [13:0]       mask_o,
  output logic [13:0]       pending_o,
  output logic [TRIG_W-1:0] rx_trig_o,
  output logic [TRIG_W-1:0] tx_trig_o,
  output logic              irq_o
);

  // reset synchronizer: asserts at once, releases after two edges
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  wr_sel_e          sel;
  logic [REG_W-1:0] ev_vec;
  logic [REG_W-1:0] live;
  logic [REG_W-1:0] pend;
  logic [REG_W-1:0] mask;
  logic             pend_clr;

  assign sel = wr_sel_e'(wr_sel_i);

  always_comb begin
    ev_vec             = '0;
    ev_vec[PD_RX_OVR]  = ev_rx_ovr_i;
    ev_vec[PD_FRAME]   = ev_frame_i;
    ev_vec[PD_PARITY]  = ev_parity_i;
    ev_vec[PD_TIMEOUT] = ev_timeout_i;
    ev_vec[PD_MODEM]   = ev_modem_i;
    ev_vec[PD_TX_OVF]  = ev_tx_ovf_i;
  end

  assign pend_clr = wr_en_i && (sel == SEL_PEND_CLR);

  uart_irq_status #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .TRIG_W     (TRIG_W)
  ) i_status (
    .rx_cnt_i (rx_count_i),
    .tx_cnt_i (tx_count_i),
    .rx_lvl_i (rx_trig_o),
    .tx_lvl_i (tx_trig_o),
    .live_o   (live)
  );

  uart_irq_pending i_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_q_n),
    .live_i     (live),
    .event_i    (ev_vec),
    .clr_en_i   (pend_clr),
    .clr_bits_i (wr_data_i),
    .pend_o     (pend)
  );

  uart_irq_ctrl #(
    .TRIG_W   (TRIG_W),
    .TRIG_RST (TRIG_RST)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_q_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wr_data_i (wr_data_i),
    .mask_o    (mask),
    .rx_lvl_o  (rx_trig_o),
    .tx_lvl_o  (tx_trig_o)
  );

  assign status_o  = live;
  assign mask_o    = mask;
  assign pending_o = pend;
  assign irq_o     = |(mask & pend);

endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk (
  input logic        clk_i,
  input logic        rst_q_n,
  input logic [13:0] status_o,
  input logic [13:0] mask_o,
  input logic [13:0] pending_o,
  input logic        irq_o,
  input logic        wr_en_i,
  input logic [2:0]  wr_sel_i,
  input logic [13:0] wr_data_i,
  input logic        ev_rx_ovr_i,
  input logic        ev_tx_ovf_i
);

  logic [13:0] clr_vec;
  assign clr_vec = (wr_en_i && (wr_sel_i == 3'd3)) ? wr_data_i : 14'd0;

  p_live_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    1'b1 |=> ((pending_o[4:0] & $past(status_o[4:0])) == $past(status_o[4:0])));

  p_txtrig_moves_r2: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    status_o[13] |=> pending_o[10]);

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    1'b1 |=> ((($past(pending_o) & ~$past(clr_vec)) & ~pending_o) == 14'd0));

  p_ovr_event_r7: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ev_rx_ovr_i |=> pending_o[5]);

  p_txovf_event_r7: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ev_tx_ovf_i |=> pending_o[12]);

  p_mask_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (wr_en_i && (wr_sel_i == 3'd2)) |=> $stable(mask_o));

  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (pending_o == 14'd0) |-> !irq_o);

  p_unused_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    !pending_o[11] && !pending_o[13] && !mask_o[11] && !mask_o[13]);

endmodule

bind uart_irq_unit uart_irq_unit_chk i_chk (
  .clk_i       (clk_i),
  .rst_q_n     (rst_q_n),
  .status_o    (status_o),
  .mask_o      (mask_o),
  .pending_o   (pending_o),
  .irq_o       (irq_o),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .ev_rx_ovr_i (ev_rx_ovr_i),
  .ev_tx_ovf_i (ev_tx_ovf_i)
);

// File: tb/test_uart_irq_unit.sv
module test_uart_irq_unit;

  localparam int DEPTH = 64;
  localparam logic [13:0] IMPL = 14'h17FF;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [6:0]  rx_count_i, tx_count_i;
  logic        ev_rx_ovr_i, ev_frame_i, ev_parity_i, ev_timeout_i, ev_modem_i, ev_tx_ovf_i;
  logic        wr_en_i;
  logic [2:0]  wr_sel_i;
  logic [13:0] wr_data_i;
  logic [13:0] status_o, mask_o, pending_o;
  logic [5:0]  rx_trig_o, tx_trig_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [13:0] m_mask, m_pend;
  logic [5:0]  m_rt, m_tt;

  always #10 clk_i = ~clk_i;

  uart_irq_unit i_uart_irq_unit (.*);

  function automatic logic [13:0] f_status(logic [6:0] rc, logic [6:0] tc,
                                           logic [5:0] rt, logic [5:0] tt);
    logic [13:0] s = '0;
    s[0]  = rc >= {1'b0, rt};
    s[1]  = rc == 7'd0;
    s[2]  = rc == 7'(DEPTH);
    s[3]  = tc == 7'd0;
    s[4]  = tc == 7'(DEPTH);
    s[13] = tc >= {1'b0, tt};
    return s;
  endfunction

  function automatic logic [13:0] f_ev(logic [5:0] ev);
    logic [13:0] v = '0;
    v[5] = ev[0]; v[6] = ev[1]; v[7] = ev[2];
    v[8] = ev[3]; v[9] = ev[4]; v[12] = ev[5];
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(logic [6:0] rc, logic [6:0] tc, logic [5:0] ev,
                      logic we, logic [2:0] sel, logic [13:0] d, string ptag);
    logic [13:0] st, set, nxt;
    @(negedge clk_i);
    rx_count_i = rc; tx_count_i = tc;
    {ev_tx_ovf_i, ev_modem_i, ev_timeout_i, ev_parity_i, ev_frame_i, ev_rx_ovr_i} = ev;
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    #1;
    st = f_status(rc, tc, m_rt, m_tt);
    check("R1 status low bits", {18'd0, status_o & ~14'h2000}, {18'd0, st & ~14'h2000});
    check("R2 status tx trigger", {31'd0, status_o[13]}, {31'd0, st[13]});
    check("R5 mask", {18'd0, mask_o}, {18'd0, m_mask});
    check(ptag, {18'd0, pending_o}, {18'd0, m_pend});
    check("R6 irq", {31'd0, irq_o}, {31'd0, |(m_mask & m_pend)});
    check("R9 triggers", {20'd0, rx_trig_o, tx_trig_o}, {20'd0, m_rt, m_tt});
    check("R10 unused bits", {28'd0, pending_o[13], pending_o[11], mask_o[13], mask_o[11]}, 32'd0);
    // model update for the coming edge
    set = f_ev(ev) | {3'b000, st[13], 5'b0, st[4:0]} & 14'h041F;
    nxt = m_pend;
    if (we && sel == 3'd3) nxt = nxt & ~d;
    m_pend = (nxt | set) & IMPL;
    if (we) begin
      case (sel)
        3'd0: m_mask = (m_mask | d) & IMPL;
        3'd1: m_mask = m_mask & ~d;
        3'd4: m_rt = d[5:0];
        3'd5: m_tt = d[5:0];
        default: ;
      endcase
    end
  endtask

  function automatic logic [6:0] pick_cnt(logic [5:0] lvl);
    case ($urandom % 6)
      0: return 7'd0;
      1: return 7'(DEPTH);
      2: return {1'b0, lvl};
      3: return (lvl == 0) ? 7'd0 : {1'b0, lvl} - 7'd1;
      default: return 7'($urandom % (DEPTH + 1));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    rx_count_i = '0; tx_count_i = '0;
    {ev_tx_ovf_i, ev_modem_i, ev_timeout_i, ev_parity_i, ev_frame_i, ev_rx_ovr_i} = '0;
    wr_en_i = 0; wr_sel_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk_i);
    // R8 reset values
    check("R8 mask at reset", {18'd0, mask_o}, 32'd0);
    check("R8 pending at reset", {18'd0, pending_o}, 32'd0);
    check("R8 triggers at reset", {20'd0, rx_trig_o, tx_trig_o}, {20'd0, 6'd32, 6'd32});
    check("R8 irq at reset", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    m_mask = '0; m_rt = 6'd32; m_tt = 6'd32;
    m_pend = 14'h000A; // R3 both FIFOs empty captured
    // R1 R2 full FIFOs
    step(7'd64, 7'd64, 6'd0, 0, 3'd0, '0, "R3 pending after empty");
    step(7'd64, 7'd64, 6'd0, 0, 3'd0, '0, "R3 pending sticky");
    // R5 direct mask write ignored
    step(7'd5, 7'd5, 6'd0, 1, 3'd2, 14'h3FFF, "R3 pending");
    step(7'd5, 7'd5, 6'd0, 1, 3'd0, 14'h3FFF, "R5 pending");
    // R4 clear all while all events strobe: events win
    step(7'd5, 7'd5, 6'h3F, 1, 3'd3, 14'h3FFF, "R4 pending");
    step(7'd5, 7'd5, 6'd0, 1, 3'd3, 14'h3FFF, "R7 pending events won clear");
    step(7'd5, 7'd5, 6'd0, 0, 3'd0, '0, "R4 pending cleared");
    // R9 triggers at extremes, spare selects
    step(7'd5, 7'd5, 6'd0, 1, 3'd4, 14'h0000, "R4 pending");
    step(7'd0, 7'd5, 6'd0, 1, 3'd5, 14'h003F, "R9 pending");
    step(7'd0, 7'd63, 6'd0, 1, 3'd6, 14'h3FFF, "R9 pending");
    step(7'd0, 7'd62, 6'd0, 1, 3'd7, 14'h3FFF, "R9 pending");
    step(7'd0, 7'd62, 6'd0, 1, 3'd1, 14'h0400, "R5 pending");
    step(7'd0, 7'd62, 6'd0, 0, 3'd0, '0, "R6 pending");
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ev;
      logic [13:0] d;
      logic [2:0] sel;
      logic we;
      ev = '0;
      for (int k = 0; k < 6; k++) ev[k] = ($urandom % 8) == 0;
      we = ($urandom % 3) == 0;
      sel = 3'($urandom);
      d = 14'($urandom);
      if ((sel == 3'd4 || sel == 3'd5) && ($urandom % 3) == 0)
        d = ($urandom % 2) ? 14'd0 : 14'd63;
      step(pick_cnt(m_rt), pick_cnt(m_tt), ev, we, sel, d, "R3/R4/R7 pending");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule